// File: doc/BRIEF.md
# Mailbox Sender Channel Window Bank

This block is the transmitting half of an inter-processor mailbox. It holds a parameterised bank of 32-bit channel windows. A local processor posts a message or raises doorbells by OR-ing bits into a window's status word through a small register port. The remote receiver drains the window by clearing bits over a dedicated clear port. When a window's status falls back to zero, the transfer is complete. If that window's interrupt is armed, the event is recorded as a sticky per-window flag.

The per-window flags are gathered into four 32-bit combined status words, so software can find the finished window with a single scan. A frame-level combine enable gates these flags onto one transmit-done interrupt line. The frame also carries an access request output toward the receiver. It samples the receiver's ready level and latches its rising and falling edges as frame-level flags.

Register reads return one cycle after the request. Each window takes a 32-byte slot starting at address 0. The frame registers sit above the highest possible window slot, starting at 0xF80.

Top module: `mbx_send_bank`

## Requirements
- R1: A read of 0xF80 returns the number of implemented windows (parameter NUM_WIN) in bits 6:0, with zeros above.
- R2: A write to window offset 0x0C ORs the written word into that window's status, readable at offset 0x00. A write to offset 0x00 has no effect on the status.
- R3: A receiver clear pulse (rxc_valid with rxc_win, rxc_mask) drops exactly the masked bits of that window's status. Status bits never rise without a set write.
- R4: When bit 0 of a window's enable (offset 0x18) is 1, bit 0 of its interrupt status (offset 0x10) becomes 1 on the cycle the status goes from nonzero to zero. It stays 1 until a write with bit 0 = 1 to offset 0x14. With the enable at 0, no flag is raised.
- R5: Combined status word k is read at 0xFA0 + 4k (k = 0..3). Window n's interrupt status appears at word n/32, bit n%32.
- R6: irq_txdone equals the OR of all combined status bits, ANDed with bit 2 of the frame enable at 0xF98.
- R7: Bit 0 written to 0xF88 drives access_req, and 0xF88 reads it back. A read of 0xF8C returns access_ready in bit 0.
- R8: The frame status at 0xF90 sets bit 0 when access_ready rises and bit 1 when it falls. Writing 1 to the matching bit at 0xF94 clears it.
- R9: Writes to windows with index NUM_WIN or above are ignored, and reads from them return zero.
- R10: After reset, all status, enable and flag registers are zero, and irq_txdone and access_req are low.
- R11: A read request returns reg_rvalid high, with its data on reg_rdata, on the cycle after it is accepted. reg_rvalid is low otherwise.
- R12: If a set write and a receiver clear hit the same window in the same cycle, the result is (old & ~mask) | set. No done event is raised if the set leaves bits standing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |
| rxc_valid | input | 1 | Receiver clear strobe |
| rxc_win | input | 7 | Window index to clear |
| rxc_mask | input | 32 | Bits to clear |
| access_req | output | 1 | Request for the receiver to become ready |
| access_ready | input | 1 | Receiver ready level |
| irq_txdone | output | 1 | Combined transmit-done interrupt |

## Verification
A corrupted status word shows up at the next status read and, if it never drains, as a missing flag and a missing interrupt. A lost or stuck done flag appears in three places in the same cycle: the window's own interrupt status, its combined word bit, and irq_txdone. A mis-decoded window index shows as a flag in the wrong combined bit or as an unimplemented window that reads back nonzero. A handshake edge missed by the frame logic is visible at the next read of the frame status.

// File: rtl/mbx_send_pkg.sv
package mbx_send_pkg;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 12;
  localparam int IDX_W      = 7;
  localparam int MAX_WIN    = 124;
  localparam int COMB_WORDS = 4;

  localparam logic [4:0] OFF_STAT = 5'h00;
  localparam logic [4:0] OFF_SET  = 5'h0C;
  localparam logic [4:0] OFF_IST  = 5'h10;
  localparam logic [4:0] OFF_ICLR = 5'h14;
  localparam logic [4:0] OFF_IEN  = 5'h18;

  localparam logic [ADDR_W-1:0] A_CFG   = 12'hF80;
  localparam logic [ADDR_W-1:0] A_AREQ  = 12'hF88;
  localparam logic [ADDR_W-1:0] A_ARDY  = 12'hF8C;
  localparam logic [ADDR_W-1:0] A_FIST  = 12'hF90;
  localparam logic [ADDR_W-1:0] A_FICLR = 12'hF94;
  localparam logic [ADDR_W-1:0] A_FIEN  = 12'hF98;
  localparam logic [ADDR_W-1:0] A_COMB0 = 12'hFA0;

  localparam int FEN_COMB = 2;
endpackage

// File: rtl/mbx_send_window.sv
module mbx_send_window
  import mbx_send_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic [WORD_W-1:0] set_data,
  input  logic              clr_hit,
  input  logic [WORD_W-1:0] clr_mask,
  input  logic              ien_we,
  input  logic              ien_bit,
  input  logic              iclr_we,
  output logic [WORD_W-1:0] status,
  output logic              irq_en,
  output logic              irq_st
);
  logic [WORD_W-1:0] status_q, status_d, clr_bits, set_bits;
  logic              en_q, en_d, ist_q, ist_d, drained, status_ce;

  always_comb begin
    clr_bits  = clr_hit ? clr_mask : '0;
    set_bits  = set_we  ? set_data : '0;
    status_d  = (status_q & ~clr_bits) | set_bits;
    status_ce = set_we | clr_hit;
    drained   = (status_q != '0) && (status_d == '0);
    en_d      = ien_we ? ien_bit : en_q;
    ist_d     = ist_q;
    if (iclr_we)          ist_d = 1'b0;
    if (drained && en_q)  ist_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      en_q     <= 1'b0;
      ist_q    <= 1'b0;
    end else begin
      if (status_ce) status_q <= status_d;
      en_q  <= en_d;
      ist_q <= ist_d;
    end
  end

  assign status = status_q;
  assign irq_en = en_q;
  assign irq_st = ist_q;

  p_set_or_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_hit) |=> (status_q == ($past(status_q) | $past(set_data))));

  p_no_spont_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !set_we |=> ((status_q & ~$past(status_q)) == '0));

  p_done_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && status_q != '0 && clr_hit && !set_we && ((status_q & ~clr_mask) == '0))
      |=> irq_st);

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ist_q && !iclr_we) |=> irq_st);
endmodule

// File: rtl/mbx_send_frame.sv
module mbx_send_frame
  import mbx_send_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       areq_we,
  input  logic       areq_bit,
  input  logic       fclr_we,
  input  logic [1:0] fclr_bits,
  input  logic       fen_we,
  input  logic [2:0] fen_bits,
  input  logic       access_ready,
  output logic       access_req,
  output logic [1:0] fstat,
  output logic [2:0] fen
);
  logic       req_q, req_d, rdy_q;
  logic [1:0] fst_q, fst_d;
  logic [2:0] fen_q, fen_d;
  logic       rise, fall;

  always_comb begin
    rise  = access_ready & ~rdy_q;
    fall  = ~access_ready & rdy_q;
    req_d = areq_we ? areq_bit : req_q;
    fen_d = fen_we ? fen_bits : fen_q;
    fst_d = fst_q;
    if (fclr_we) fst_d = fst_d & ~fclr_bits;
    if (rise)    fst_d[0] = 1'b1;
    if (fall)    fst_d[1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      rdy_q <= 1'b0;
      fst_q <= '0;
      fen_q <= '0;
    end else begin
      req_q <= req_d;
      rdy_q <= access_ready;
      fst_q <= fst_d;
      fen_q <= fen_d;
    end
  end

  assign access_req = req_q;
  assign fstat      = fst_q;
  assign fen        = fen_q;

  p_req_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    areq_we |=> (access_req == $past(areq_bit)));

  p_rise_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (access_ready && !rdy_q) |=> fstat[0]);

  p_fall_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!access_ready && rdy_q) |=> fstat[1]);
endmodule

// File: rtl/mbx_send_bank.sv
module mbx_send_bank
  import mbx_send_pkg::*;
#(
  parameter int NUM_WIN = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              reg_rvalid,
  output logic [31:0]       reg_rdata,
  input  logic              rxc_valid,
  input  logic [6:0]        rxc_win,
  input  logic [31:0]       rxc_mask,
  output logic              access_req,
  input  logic              access_ready,
  output logic              irq_txdone
);
  localparam int COMB_BITS = COMB_WORDS * WORD_W;

  logic              wr, rd, in_win_area, hit_win;
  logic [IDX_W-1:0]  win_idx;
  logic [4:0]        win_off;
  logic [WORD_W-1:0] win_stat [NUM_WIN];
  logic [NUM_WIN-1:0] win_en, win_ist;
  logic [COMB_BITS-1:0] comb_vec;
  logic [1:0]        fstat;
  logic [2:0]        fen;
  logic [WORD_W-1:0] rd_d, rdata_q;
  logic              rvalid_q;

  assign wr          = reg_valid &  reg_write;
  assign rd          = reg_valid & ~reg_write;
  assign win_idx     = reg_addr[11:5];
  assign win_off     = reg_addr[4:0];
  assign in_win_area = reg_addr < A_CFG;
  assign hit_win     = in_win_area && (win_idx < IDX_W'(NUM_WIN));

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic sel;
    assign sel = wr && hit_win && (win_idx == IDX_W'(i));
    mbx_send_window u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_we   (sel && win_off == OFF_SET),
      .set_data (reg_wdata),
      .clr_hit  (rxc_valid && rxc_win == IDX_W'(i)),
      .clr_mask (rxc_mask),
      .ien_we   (sel && win_off == OFF_IEN),
      .ien_bit  (reg_wdata[0]),
      .iclr_we  (sel && win_off == OFF_ICLR && reg_wdata[0]),
      .status   (win_stat[i]),
      .irq_en   (win_en[i]),
      .irq_st   (win_ist[i])
    );
  end

  always_comb begin
    comb_vec = '0;
    comb_vec[NUM_WIN-1:0] = win_ist;
  end

  mbx_send_frame u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .areq_we      (wr && reg_addr == A_AREQ),
    .areq_bit     (reg_wdata[0]),
    .fclr_we      (wr && reg_addr == A_FICLR),
    .fclr_bits    (reg_wdata[1:0]),
    .fen_we       (wr && reg_addr == A_FIEN),
    .fen_bits     (reg_wdata[2:0]),
    .access_ready (access_ready),
    .access_req   (access_req),
    .fstat        (fstat),
    .fen          (fen)
  );

  assign irq_txdone = (|comb_vec) & fen[FEN_COMB];

  always_comb begin
    rd_d = '0;
    if (hit_win) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (win_idx == IDX_W'(i)) begin
          case (win_off)
            OFF_STAT: rd_d = win_stat[i];
            OFF_IST:  rd_d = {31'b0, win_ist[i]};
            OFF_IEN:  rd_d = {31'b0, win_en[i]};
            default:  rd_d = '0;
          endcase
        end
      end
    end else if (!in_win_area) begin
      case (reg_addr)
        A_CFG:   rd_d = {25'b0, IDX_W'(NUM_WIN)};
        A_AREQ:  rd_d = {31'b0, access_req};
        A_ARDY:  rd_d = {31'b0, access_ready};
        A_FIST:  rd_d = {30'b0, fstat};
        A_FIEN:  rd_d = {29'b0, fen};
        default: rd_d = '0;
      endcase
      for (int k = 0; k < COMB_WORDS; k++) begin
        if (reg_addr == A_COMB0 + ADDR_W'(4 * k)) rd_d = comb_vec[k*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_d;
    end
  end

  assign reg_rvalid = rvalid_q;
  assign reg_rdata  = rdata_q;

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fen[FEN_COMB] |-> !irq_txdone);

  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> reg_rvalid);

  p_rvalid_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !reg_rvalid);
endmodule

// File: tb/mbx_send_bank_tb.sv
module mbx_send_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_valid, reg_write;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_rvalid;
  logic [31:0] reg_rdata;
  logic        rxc_valid;
  logic [6:0]  rxc_win;
  logic [31:0] rxc_mask;
  logic        access_req, access_ready, irq_txdone;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_send_bank #(.NUM_WIN(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
    .reg_rdata(reg_rdata), .rxc_valid(rxc_valid), .rxc_win(rxc_win),
    .rxc_mask(rxc_mask), .access_req(access_req), .access_ready(access_ready),
    .irq_txdone(irq_txdone)
  );

  function automatic logic [11:0] wa(int idx, int off);
    return 12'(idx * 32 + off);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (exp_q.size() == 0) chk("R11 unexpected rvalid", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic rx_clear(int w, logic [31:0] m);
    @(negedge clk);
    rxc_valid = 1'b1; rxc_win = 7'(w); rxc_mask = m;
    @(negedge clk);
    rxc_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_valid = 0; reg_write = 0; reg_addr = '0; reg_wdata = '0;
    rxc_valid = 0; rxc_win = '0; rxc_mask = '0; access_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 irq after reset", {31'b0, irq_txdone}, 32'd0);
    chk("R10 access_req after reset", {31'b0, access_req}, 32'd0);
    chk("R11 rvalid idle", {31'b0, reg_rvalid}, 32'd0);
    bus_read(wa(0, 'h00), 32'h0, "R10 status reset");
    bus_read(12'hFA0, 32'h0, "R10 comb reset");
    // R1
    bus_read(12'hF80, NW, "R1 cfg window count");
    // R2 set ORs, direct status write ignored
    bus_write(wa(3, 'h0C), 32'h0000_00F0);
    bus_write(wa(3, 'h0C), 32'h0000_0005);
    bus_read(wa(3, 'h00), 32'h0000_00F5, "R2 status OR");
    bus_write(wa(3, 'h00), 32'hFFFF_0000);
    bus_read(wa(3, 'h00), 32'h0000_00F5, "R2 status write ignored");
    // R3 partial clear
    rx_clear(3, 32'h0000_000F);
    bus_read(wa(3, 'h00), 32'h0000_00F0, "R3 partial clear");
    bus_read(wa(3, 'h10), 32'h0, "R4 no flag while bits remain");
    // R4/R5/R6 drain with enable
    bus_write(wa(3, 'h18), 32'h1);
    bus_write(12'hF98, 32'h4);
    chk("R6 irq low before drain", {31'b0, irq_txdone}, 32'd0);
    rx_clear(3, 32'h0000_00F0);
    chk("R6 irq after drain", {31'b0, irq_txdone}, 32'd1);
    bus_read(wa(3, 'h00), 32'h0, "R3 drained");
    bus_read(wa(3, 'h10), 32'h1, "R4 flag set");
    bus_read(12'hFA0, 32'h0000_0008, "R5 comb word0 bit3");
    bus_write(12'hF98, 32'h0);
    chk("R6 irq gated off", {31'b0, irq_txdone}, 32'd0);
    bus_write(12'hF98, 32'h4);
    chk("R6 irq gated on", {31'b0, irq_txdone}, 32'd1);
    bus_write(wa(3, 'h14), 32'h0);
    bus_read(wa(3, 'h10), 32'h1, "R4 clear with bit0=0 ignored");
    bus_write(wa(3, 'h14), 32'h1);
    bus_read(wa(3, 'h10), 32'h0, "R4 flag cleared");
    chk("R6 irq after ack", {31'b0, irq_txdone}, 32'd0);
    // R5 second word
    bus_write(wa(35, 'h18), 32'h1);
    bus_write(wa(35, 'h0C), 32'h1);
    rx_clear(35, 32'h1);
    bus_read(12'hFA4, 32'h0000_0008, "R5 comb word1 bit3");
    bus_read(12'hFA0, 32'h0, "R5 comb word0 clear");
    bus_write(wa(35, 'h14), 32'h1);
    bus_read(12'hFA4, 32'h0, "R5 comb word1 after ack");
    // R4 disabled window raises nothing
    bus_write(wa(7, 'h0C), 32'h8000_0000);
    rx_clear(7, 32'hFFFF_FFFF);
    bus_read(wa(7, 'h10), 32'h0, "R4 disabled no flag");
    chk("R6 irq stays low", {31'b0, irq_txdone}, 32'd0);
    // R12 simultaneous set and clear
    bus_write(wa(5, 'h18), 32'h1);
    bus_write(wa(5, 'h0C), 32'h3);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = wa(5, 'h0C); reg_wdata = 32'h10;
    rxc_valid = 1; rxc_win = 7'd5; rxc_mask = 32'h3;
    @(negedge clk);
    reg_valid = 0; reg_write = 0; rxc_valid = 0;
    bus_read(wa(5, 'h00), 32'h10, "R12 set and clear merge");
    bus_read(wa(5, 'h10), 32'h0, "R12 no done event");
    // R9 unimplemented window
    bus_write(wa(50, 'h0C), 32'hFF);
    bus_write(wa(50, 'h18), 32'h1);
    bus_read(wa(50, 'h00), 32'h0, "R9 unimpl status");
    bus_read(wa(50, 'h18), 32'h0, "R9 unimpl enable");
    bus_read(12'hFA4, 32'h0, "R9 comb word1 untouched");
    // R7/R8 handshake
    bus_write(12'hF88, 32'h1);
    chk("R7 access_req set", {31'b0, access_req}, 32'd1);
    bus_read(12'hF88, 32'h1, "R7 request readback");
    bus_read(12'hF8C, 32'h0, "R7 ready low");
    @(negedge clk); access_ready = 1'b1;
    bus_read(12'hF8C, 32'h1, "R7 ready high");
    bus_read(12'hF90, 32'h1, "R8 rise flag");
    @(negedge clk); access_ready = 1'b0;
    bus_read(12'hF90, 32'h3, "R8 fall flag");
    bus_write(12'hF94, 32'h1);
    bus_read(12'hF90, 32'h2, "R8 clear rise only");
    bus_write(12'hF94, 32'h2);
    bus_read(12'hF90, 32'h0, "R8 clear fall");
    bus_write(12'hF88, 32'h0);
    chk("R7 access_req released", {31'b0, access_req}, 32'd0);
    @(negedge clk);
    chk("R11 rvalid idle after reads", {31'b0, reg_rvalid}, 32'd0);
    chk("R11 scoreboard drained", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule